// File: doc/BRIEF.md
# Memory Access Fault Screen

This block screens every pending load/store and every decoded instruction before it commits. Each cycle it looks at the access address, the access size (word or byte), a valid strobe, a write request, the current privilege level, and the opcode field of the instruction being decoded. From these it decides whether a fault must be taken. When an access faults, the block cancels it in the same cycle, so a store never reaches memory and a load result is discarded.

Three fault causes are recognised:

- **Privilege violation.** A user-mode access falls inside the low system region. The region runs from address zero up to the `SYS_TOP` parameter, inclusive.
- **Misaligned word access.** A word access uses an odd address.
- **Reserved opcode.** The opcode is one of the two reserved values.

When several causes are present in the same cycle, a fixed priority picks one. The chosen 8-bit vector is loaded into a holding register on the next clock edge. The fault-entry sequencer reads the vector from that register and releases it with an acknowledge pulse.

Top module: `exc_checker`

## Requirements
- R1: A valid access in user mode (`user_mode`=1) whose address is at or below `SYS_TOP` raises `exc_req` and selects vector 8'h02.
- R2: In supervisor mode (`user_mode`=0), no address raises the privilege fault.
- R3: A valid word access (`acc_word`=1) with address bit 0 set raises `exc_req` and selects vector 8'h03, in either privilege mode.
- R4: A byte access (`acc_word`=0) never raises the misalignment fault, whatever the address parity.
- R5: When privilege and misalignment faults coincide, vector 8'h02 is selected. For example, a user word store to address 1 yields 8'h02.
- R6: With `op_valid`=1, opcode 4'b1010 or 4'b1011 raises `exc_req` with vector 8'h04. All other opcode values raise nothing.
- R7: In the same cycle, an access fault outranks a reserved-opcode fault.
- R8: In the cycle an access fault is present, `cancel`=1 and `mem_we_out`=0. A valid access with no access fault passes `acc_write` through to `mem_we_out` with `cancel`=0.
- R9: A fault seen while `vec_valid`=0 loads `exc_vec` and sets `vec_valid` at the next clock edge. Without `vec_ack`, the register and its flag hold, and later faults do not overwrite them.
- R10: After reset, `vec_valid`=0 and `exc_vec`=8'h00.
- R11: `vec_ack` with no fault clears `vec_valid` (and `exc_vec`) at the next edge. `vec_ack` together with a fault loads the new vector instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A memory access is pending this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_word | input | 1 | 1 = word access, 0 = byte access |
| acc_write | input | 1 | Access is a store |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| op_valid | input | 1 | `opcode` holds a freshly decoded instruction |
| opcode | input | 4 | Opcode field |
| vec_ack | input | 1 | Sequencer has consumed the held vector |
| exc_req | output | 1 | A fault is present this cycle |
| cancel | output | 1 | Block the pending memory access |
| mem_we_out | output | 1 | Gated write enable towards memory |
| exc_vec | output | 8 | Held fault vector |
| vec_valid | output | 1 | `exc_vec` holds an unconsumed vector |

## Verification
The bench builds the block with `ADDR_W`=8 and `SYS_TOP`=8'h2F. This shrinks the address space to 256 values while keeping both sides of the privilege boundary and both address parities. Every address is then swept against every combination of privilege and access size, and the boundary at 8'h2F/8'h30 falls inside that sweep. A separate pass covers all sixteen opcodes. Directed sequences drive the holding register through hold, overwrite attempts, clear, and simultaneous acknowledge-with-fault.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_W = 8;
    localparam int OP_W  = 4;

    localparam logic [VEC_W-1:0] VEC_NONE  = 8'h00;
    localparam logic [VEC_W-1:0] VEC_PRIV  = 8'h02;
    localparam logic [VEC_W-1:0] VEC_ALIGN = 8'h03;
    localparam logic [VEC_W-1:0] VEC_RSVD  = 8'h04;

    // Cause order is priority order: lower index wins.
    localparam int N_CAUSE = 3;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_PRIV  = 2'd1,
        CAUSE_ALIGN = 2'd2,
        CAUSE_RSVD  = 2'd3
    } cause_e;

    typedef struct packed {
        logic rsvd;   // index 2
        logic align;  // index 1
        logic priv;   // index 0
    } fault_flags_t;

    function automatic logic op_reserved(input logic [OP_W-1:0] op);
        return (op == 4'b1010) || (op == 4'b1011);
    endfunction

    function automatic logic [VEC_W-1:0] cause_vec(input cause_e c);
        case (c)
            CAUSE_PRIV:  return VEC_PRIV;
            CAUSE_ALIGN: return VEC_ALIGN;
            CAUSE_RSVD:  return VEC_RSVD;
            default:     return VEC_NONE;
        endcase
    endfunction

    function automatic cause_e idx_cause(input int idx);
        case (idx)
            0:       return CAUSE_PRIV;
            1:       return CAUSE_ALIGN;
            2:       return CAUSE_RSVD;
            default: return CAUSE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/exc_fault_detect.sv
module exc_fault_detect
    import exc_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SYS_TOP = 'h2FFF
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_word,
    input  logic              user_mode,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   opcode,
    output fault_flags_t      flags
);
    logic in_sys_region;
    logic odd_addr;

    always_comb begin
        in_sys_region = (acc_addr <= SYS_TOP);
        odd_addr      = acc_addr[0];
        flags.priv    = acc_valid && user_mode && in_sys_region;
        flags.align   = acc_valid && acc_word && odd_addr;
        flags.rsvd    = op_valid && op_reserved(opcode);
    end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
(
    input  fault_flags_t      flags,
    output logic              any_fault,
    output logic              acc_fault,
    output cause_e            cause,
    output logic [VEC_W-1:0]  vec
);
    logic [N_CAUSE-1:0] flag_vec;
    cause_e             stage [N_CAUSE+1];

    assign flag_vec = flags;
    assign stage[N_CAUSE] = CAUSE_NONE;

    // Walk from lowest to highest priority; a higher one overrides.
    for (genvar i = N_CAUSE - 1; i >= 0; i--) begin : g_stage
        assign stage[i] = flag_vec[i] ? idx_cause(i) : stage[i+1];
    end

    always_comb begin
        cause     = stage[0];
        any_fault = |flag_vec;
        acc_fault = flags.priv || flags.align;
        vec       = cause_vec(stage[0]);
    end
endmodule

// File: rtl/exc_vec_reg.sv
module exc_vec_reg
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fault,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic              ack,
    output logic [VEC_W-1:0]  vec_q,
    output logic              valid_q
);
    logic load;
    logic clear;

    always_comb begin
        load  = fault && (!valid_q || ack);
        clear = ack && !fault;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q   <= VEC_NONE;
            valid_q <= 1'b0;
        end else if (load) begin
            vec_q   <= vec_in;
            valid_q <= 1'b1;
        end else if (clear) begin
            vec_q   <= VEC_NONE;
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/exc_checker.sv
module exc_checker
    import exc_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SYS_TOP = 'h2FFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_word,
    input  logic              acc_write,
    input  logic              user_mode,
    input  logic              op_valid,
    input  logic [3:0]        opcode,
    input  logic              vec_ack,
    output logic              exc_req,
    output logic              cancel,
    output logic              mem_we_out,
    output logic [7:0]        exc_vec,
    output logic              vec_valid
);
    fault_flags_t      flags;
    logic              any_fault;
    logic              acc_fault;
    cause_e            cause;
    logic [VEC_W-1:0]  sel_vec;

    exc_fault_detect #(.ADDR_W(ADDR_W), .SYS_TOP(SYS_TOP)) u_detect (
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_word  (acc_word),
        .user_mode (user_mode),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .flags     (flags)
    );

    exc_prio u_prio (
        .flags     (flags),
        .any_fault (any_fault),
        .acc_fault (acc_fault),
        .cause     (cause),
        .vec       (sel_vec)
    );

    exc_vec_reg u_vreg (
        .clk     (clk),
        .rst     (rst),
        .fault   (any_fault),
        .vec_in  (sel_vec),
        .ack     (vec_ack),
        .vec_q   (exc_vec),
        .valid_q (vec_valid)
    );

    logic unused_cause;
    assign unused_cause = ^cause;

    always_comb begin
        exc_req    = any_fault;
        cancel     = acc_fault;
        mem_we_out = acc_valid && acc_write && !acc_fault;
    end
endmodule

// File: rtl/exc_checker_sva.sv
module exc_checker_sva #(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] SYS_TOP = 'h2FFF
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_word,
    input logic              acc_write,
    input logic              user_mode,
    input logic              op_valid,
    input logic [3:0]        opcode,
    input logic              vec_ack,
    input logic              exc_req,
    input logic              cancel,
    input logic              mem_we_out,
    input logic [7:0]        exc_vec,
    input logic              vec_valid
);
    logic priv_hit;
    logic free_slot;
    assign priv_hit  = acc_valid && user_mode && (acc_addr <= SYS_TOP);
    assign free_slot = !vec_valid || vec_ack;

    // R1, R5
    a_r1_priv_vector: assert property (@(posedge clk) disable iff (rst)
        (priv_hit && free_slot) |=> (vec_valid && exc_vec == 8'h02));

    // R3
    a_r3_align_vector: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_word && acc_addr[0] && !priv_hit && free_slot)
            |=> (vec_valid && exc_vec == 8'h03));

    // R6, R7
    a_r6_rsvd_vector: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (opcode == 4'b1010 || opcode == 4'b1011) && !acc_valid && free_slot)
            |=> (vec_valid && exc_vec == 8'h04));

    // R2, R4
    a_r4_quiet_access: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_word && !priv_hit && !op_valid) |-> (!exc_req && !cancel));

    // R8
    a_r8_cancel_blocks_write: assert property (@(posedge clk) disable iff (rst)
        cancel |-> !mem_we_out);

    a_r8_clean_write_passes: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !priv_hit && !(acc_word && acc_addr[0])) |-> mem_we_out);

    // R9
    a_r9_hold_vector: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ack) |=> (vec_valid && $stable(exc_vec)));

    // R11
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (vec_ack && !exc_req) |=> !vec_valid);
endmodule

bind exc_checker exc_checker_sva #(.ADDR_W(ADDR_W), .SYS_TOP(SYS_TOP)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_word   (acc_word),
    .acc_write  (acc_write),
    .user_mode  (user_mode),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .vec_ack    (vec_ack),
    .exc_req    (exc_req),
    .cancel     (cancel),
    .mem_we_out (mem_we_out),
    .exc_vec    (exc_vec),
    .vec_valid  (vec_valid)
);

// File: tb/sim_exc_checker.sv
module sim_exc_checker;
    localparam int        AW   = 8;
    localparam logic [7:0] STOP = 8'h2F;

    logic          clk = 1'b0;
    logic          rst;
    logic          acc_valid, acc_word, acc_write, user_mode, op_valid, vec_ack;
    logic [AW-1:0] acc_addr;
    logic [3:0]    opcode;
    logic          exc_req, cancel, mem_we_out, vec_valid;
    logic [7:0]    exc_vec;

    int checks = 0;
    int errors = 0;

    // Bench model of the holding register
    logic       m_valid;
    logic [7:0] m_vec;

    always #10 clk = ~clk;

    exc_checker #(.ADDR_W(AW), .SYS_TOP(STOP)) u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_word(acc_word), .acc_write(acc_write), .user_mode(user_mode),
        .op_valid(op_valid), .opcode(opcode), .vec_ack(vec_ack),
        .exc_req(exc_req), .cancel(cancel), .mem_we_out(mem_we_out),
        .exc_vec(exc_vec), .vec_valid(vec_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] exp_vec(input logic av, input logic um, input logic wd,
                                           input logic [AW-1:0] a, input logic ov,
                                           input logic [3:0] op);
        if (av && um && a <= STOP)                   return 8'h02;
        if (av && wd && a[0])                        return 8'h03;
        if (ov && (op == 4'hA || op == 4'hB))        return 8'h04;
        return 8'h00;
    endfunction

    function automatic string vec_tag(input logic [7:0] v, input logic um);
        case (v)
            8'h02:   return "R1/R5";
            8'h03:   return "R3";
            8'h04:   return "R6/R7";
            default: return um ? "R4" : "R2/R4";
        endcase
    endfunction

    task automatic step(input logic av, input logic um, input logic wd, input logic wr,
                        input logic [AW-1:0] a, input logic ov, input logic [3:0] op,
                        input logic ak);
        logic [7:0] ev;
        logic       afault;
        @(negedge clk);
        acc_valid = av; user_mode = um; acc_word = wd; acc_write = wr;
        acc_addr = a; op_valid = ov; opcode = op; vec_ack = ak;
        ev     = exp_vec(av, um, wd, a, ov, op);
        afault = (ev == 8'h02) || (ev == 8'h03);
        #5;
        chk({vec_tag(ev, um), " exc_req"}, int'(exc_req), int'(ev != 8'h00));
        chk("R8 cancel",     int'(cancel),     int'(afault));
        chk("R8 mem_we_out", int'(mem_we_out), int'(av && wr && !afault));
        if (ev != 8'h00 && (!m_valid || ak)) begin
            m_valid = 1'b1; m_vec = ev;
        end else if (ak && ev == 8'h00) begin
            m_valid = 1'b0; m_vec = 8'h00;
        end
        @(posedge clk);
        #5;
        chk({vec_tag(ev, um), " R9/R11 exc_vec"}, int'(exc_vec), int'(m_vec));
        chk("R9/R11 vec_valid", int'(vec_valid), int'(m_valid));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        rst = 1'b1; acc_valid = 0; acc_word = 0; acc_write = 0; user_mode = 0;
        op_valid = 0; opcode = 0; vec_ack = 0; acc_addr = '0;
        m_valid = 0; m_vec = 0;
        repeat (3) @(posedge clk);
        #5;
        chk("R10 vec_valid after reset", int'(vec_valid), 0);
        chk("R10 exc_vec after reset",   int'(exc_vec),   0);
        @(negedge clk);
        rst = 1'b0;

        // Full sweep: privilege x size x address, ack every cycle so each result loads.
        for (int um = 0; um < 2; um++)
            for (int wd = 0; wd < 2; wd++)
                for (int a = 0; a < 256; a++)
                    step(1'b1, um[0], wd[0], a[0] ^ um[0], a[AW-1:0], 1'b0, 4'h0, 1'b1);

        // Opcode sweep with no access pending (R6).
        for (int op = 0; op < 16; op++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 8'h40, 1'b1, op[3:0], 1'b1);

        // R7: access faults outrank reserved opcode.
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 4'hA, 1'b1);
        step(1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 1'b1, 4'hB, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1, 4'hB, 1'b1);

        // R5 example: user word store to address 1.
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1);
        step(1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 1'b0, 4'h0, 1'b0);
        chk("R5 user word store to 1", int'(exc_vec), 8'h02);

        // R9: hold without ack; later faults do not overwrite.
        step(1'b1, 1'b0, 1'b1, 1'b0, 8'h91, 1'b0, 4'h0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'hB, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4'h0, 1'b0);
        chk("R9 held vector", int'(exc_vec), 8'h02);

        // R11: ack with fault loads new, ack without fault clears.
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'hA, 1'b1);
        chk("R11 ack+fault loads", int'(exc_vec), 8'h04);
        step(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1);
        chk("R11 ack clears", int'(vec_valid), 0);

        // R10: reset mid-hold.
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 4'h0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #5;
        chk("R10 reset clears held vector", int'(vec_valid), 0);
        report();
    end
endmodule